// File: doc/BRIEF.md
# Pulse-Frequency Buck Transfer Controller

This block sequences the switches of a pulse-frequency-modulated buck stage that keeps a rectifier node near a chosen voltage by dumping its charge into a fixed storage voltage. A slow sampling strobe, one pulse per sampling period (about 20 kHz in a typical system), marks the moment at which the registered result of an external comparator is examined. When the comparator says the divided rectifier voltage sits above its reference, the controller asks an external arbiter for the shared inductor. Once the grant arrives, it drives the high-side switch for a fixed number of delay units, leaves both switches off for one cycle, drives the low-side switch for a number of units looked up from the setpoint code, and then hands the inductor back with a one-cycle release pulse.

The low-side duration is chosen open-loop. No current is sensed. The entry for each of the sixteen setpoint codes is sized so that the inductor current decays to about zero at the end of the low-side phase. The code spans rectifier targets from 2.2 V to 5 V in equal steps, and the storage node sits at 1.8 V. One delay unit lasts a parameterised number of clock cycles.

Top module: `pfm_buck_ctrl`

## Requirements
- R1: After reset, every output (inductor request, release, high-side drive, low-side drive) is low.
- R2: A strobe cycle with the comparator high raises the request in the next cycle. A strobe with the comparator low raises nothing, and the comparator is ignored in cycles without a strobe.
- R3: The request stays high until a cycle in which the grant is high. In the following cycle the request is low and the high-side drive is high.
- R4: The high-side and low-side drives are never high in the same cycle.
- R5: The high-side drive stays high for exactly HS_UNITS × UNIT_CYC consecutive cycles (defaults 8 × 2 = 16).
- R6: Exactly one cycle with both drives low separates the end of the high-side phase from the start of the low-side phase.
- R7: The low-side drive stays high for LS_TABLE[code] × UNIT_CYC cycles. Entry k of LS_TABLE is held in bits [5k+4:5k]. By default, entry k equals round(HS_UNITS × (V_k − 1.8) / 1.8), where V_k = 2.2 + 2.8·k/15.
- R8: The setpoint code is captured in the grant cycle. A change of the code later in the transfer does not alter that transfer's low-side duration.
- R9: The release is high for exactly one cycle. That cycle directly follows the last low-side cycle. Afterwards the block is idle with all outputs low.
- R10: A strobe with the comparator high that arrives while a transfer is pending or active starts no further transfer. No request follows the release until a later strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock; one delay unit is UNIT_CYC of its cycles |
| rst_n | input | 1 | Asynchronous active-low reset |
| samp_tick | input | 1 | One-cycle strobe marking each comparator sampling instant |
| cmp_above | input | 1 | Comparator result: divided rectifier voltage above reference |
| vset_code | input | 4 | Regulation setpoint code, 0 = lowest target voltage |
| ind_gnt | input | 1 | Inductor grant from the arbiter |
| ind_req | output | 1 | Inductor request, held until granted |
| ind_rel | output | 1 | One-cycle inductor release pulse |
| hs_on | output | 1 | High-side switch drive |
| ls_on | output | 1 | Low-side switch drive |

## Verification
The bound checker checks the following on every cycle: the two drives never overlap, the request is held until granted, the high-side phase starts right after the grant, the dead cycle occurs, the high-side phase has its full length, and the release is a single pulse right after the low-side phase. It also checks that each request can be traced back to a strobe with the comparator high. Only the bench scenarios can show the following: that each low-side duration matches the volt-second ratio for its code, that the code is captured at the grant and not later, and that strobes arriving mid-transfer are dropped. These checks need values computed outside the design and a record of what was applied earlier.

// File: rtl/pfm_pkg.sv
package pfm_pkg;

   typedef enum logic [2:0] {
      ST_IDLE,
      ST_REQ,
      ST_HS,
      ST_DEAD,
      ST_LS,
      ST_REL
   } pfm_state_e;

   localparam int unsigned PFM_CODES  = 16;
   localparam int unsigned PFM_UNIT_W = 5;

   // Low-side units per setpoint code for an 8-unit high-side phase, entry 15 first.
   localparam logic [PFM_CODES*PFM_UNIT_W-1:0] PFM_LS_DEFAULT = {
      5'd14, 5'd13, 5'd13, 5'd12, 5'd11, 5'd10, 5'd9, 5'd8,
      5'd8,  5'd7,  5'd6,  5'd5,  5'd4,  5'd3,  5'd3, 5'd2
   };

endpackage

// File: rtl/pfm_sample_gate.sv
module pfm_sample_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic samp_tick,
   input  logic cmp_above,
   input  logic idle,
   output logic start
);
   logic armed_q;

   // The strobe only counts when the sequencer is idle; anything else is dropped.
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed_q <= 1'b0;
      else        armed_q <= 1'b1;
   end

   assign start = armed_q & idle & samp_tick & cmp_above;
endmodule

// File: rtl/pfm_ontime_sel.sv
module pfm_ontime_sel #(
   parameter int unsigned UNIT_W  = 5,
   parameter int unsigned CODES   = 16,
   parameter bit          LUT_REG = 1'b1,
   parameter logic [CODES*UNIT_W-1:0] LS_TABLE = '0,
   localparam int unsigned CODE_W = $clog2(CODES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [CODE_W-1:0] code,
   output logic [UNIT_W-1:0] ls_units
);
   generate
      if (LUT_REG) begin : g_store_units
         logic [UNIT_W-1:0] units_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       units_q <= '0;
            else if (capture) units_q <= LS_TABLE[code*UNIT_W +: UNIT_W];
         end
         assign ls_units = units_q;
      end else begin : g_store_code
         logic [CODE_W-1:0] code_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)       code_q <= '0;
            else if (capture) code_q <= code;
         end
         assign ls_units = LS_TABLE[code_q*UNIT_W +: UNIT_W];
      end
   endgenerate
endmodule

// File: rtl/pfm_unit_timer.sv
module pfm_unit_timer #(
   parameter int unsigned UNIT_W   = 5,
   parameter int unsigned UNIT_CYC = 2,
   localparam int unsigned PRE_W   = (UNIT_CYC > 1) ? $clog2(UNIT_CYC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [UNIT_W-1:0] units,
   output logic              done
);
   localparam logic [PRE_W-1:0] PRE_TOP = PRE_W'(UNIT_CYC - 1);

   logic [UNIT_W-1:0] unit_q;
   logic [PRE_W-1:0]  pre_q;
   logic              run_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         unit_q <= '0;
         pre_q  <= '0;
         run_q  <= 1'b0;
      end else if (load) begin
         unit_q <= units - 1'b1;
         pre_q  <= PRE_TOP;
         run_q  <= 1'b1;
      end else if (run_q) begin
         if (pre_q == '0) begin
            pre_q <= PRE_TOP;
            if (unit_q == '0) run_q  <= 1'b0;
            else              unit_q <= unit_q - 1'b1;
         end else begin
            pre_q <= pre_q - 1'b1;
         end
      end
   end

   assign done = run_q && (pre_q == '0) && (unit_q == '0);
endmodule

// File: rtl/pfm_seq.sv
module pfm_seq
   import pfm_pkg::*;
#(
   parameter int unsigned UNIT_W   = 5,
   parameter int unsigned HS_UNITS = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic              ind_gnt,
   input  logic              tmr_done,
   input  logic [UNIT_W-1:0] ls_units,
   output logic              idle,
   output logic              capture,
   output logic              tmr_load,
   output logic [UNIT_W-1:0] tmr_units,
   output logic              ind_req,
   output logic              ind_rel,
   output logic              hs_on,
   output logic              ls_on
);
   localparam logic [UNIT_W-1:0] HS_U = UNIT_W'(HS_UNITS);

   pfm_state_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: if (start)    st_d = ST_REQ;
         ST_REQ:  if (ind_gnt)  st_d = ST_HS;
         ST_HS:   if (tmr_done) st_d = ST_DEAD;
         ST_DEAD:               st_d = ST_LS;
         ST_LS:   if (tmr_done) st_d = ST_REL;
         ST_REL:                st_d = ST_IDLE;
         default:               st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign capture   = (st_q == ST_REQ) && ind_gnt;
   assign tmr_load  = capture || (st_q == ST_DEAD);
   assign tmr_units = capture ? HS_U : ls_units;

   assign idle    = (st_q == ST_IDLE);
   assign ind_req = (st_q == ST_REQ);
   assign ind_rel = (st_q == ST_REL);
   assign hs_on   = (st_q == ST_HS);
   assign ls_on   = (st_q == ST_LS);
endmodule

// File: rtl/pfm_buck_ctrl.sv
module pfm_buck_ctrl #(
   parameter int unsigned HS_UNITS = 8,
   parameter int unsigned UNIT_CYC = 2,
   parameter bit          LUT_REG  = 1'b1,
   parameter logic [pfm_pkg::PFM_CODES*pfm_pkg::PFM_UNIT_W-1:0] LS_TABLE = pfm_pkg::PFM_LS_DEFAULT
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       samp_tick,
   input  logic       cmp_above,
   input  logic [3:0] vset_code,
   input  logic       ind_gnt,
   output logic       ind_req,
   output logic       ind_rel,
   output logic       hs_on,
   output logic       ls_on
);
   localparam int unsigned UNIT_W = pfm_pkg::PFM_UNIT_W;
   localparam int unsigned CODES  = pfm_pkg::PFM_CODES;

   generate
      if (HS_UNITS < 1 || HS_UNITS >= (1 << UNIT_W)) begin : g_bad_hs
         $error("HS_UNITS out of range");
      end
      if (UNIT_CYC < 1) begin : g_bad_cyc
         $error("UNIT_CYC must be at least 1");
      end
      for (genvar k = 0; k < CODES; k++) begin : g_tbl_chk
         if (LS_TABLE[k*UNIT_W +: UNIT_W] == '0) begin : g_zero
            $error("LS_TABLE entry must be nonzero");
         end
      end
   endgenerate

   logic              start, idle, capture, tmr_load, tmr_done;
   logic [UNIT_W-1:0] ls_units, tmr_units;

   pfm_sample_gate u_gate (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_tick (samp_tick),
      .cmp_above (cmp_above),
      .idle      (idle),
      .start     (start)
   );

   pfm_ontime_sel #(
      .UNIT_W   (UNIT_W),
      .CODES    (CODES),
      .LUT_REG  (LUT_REG),
      .LS_TABLE (LS_TABLE)
   ) u_sel (
      .clk      (clk),
      .rst_n    (rst_n),
      .capture  (capture),
      .code     (vset_code),
      .ls_units (ls_units)
   );

   pfm_unit_timer #(
      .UNIT_W   (UNIT_W),
      .UNIT_CYC (UNIT_CYC)
   ) u_tmr (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (tmr_load),
      .units (tmr_units),
      .done  (tmr_done)
   );

   pfm_seq #(
      .UNIT_W   (UNIT_W),
      .HS_UNITS (HS_UNITS)
   ) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .ind_gnt   (ind_gnt),
      .tmr_done  (tmr_done),
      .ls_units  (ls_units),
      .idle      (idle),
      .capture   (capture),
      .tmr_load  (tmr_load),
      .tmr_units (tmr_units),
      .ind_req   (ind_req),
      .ind_rel   (ind_rel),
      .hs_on     (hs_on),
      .ls_on     (ls_on)
   );
endmodule

// File: rtl/pfm_buck_ctrl_chk.sv
module pfm_buck_ctrl_chk #(
   parameter int unsigned HS_UNITS = 8,
   parameter int unsigned UNIT_CYC = 2
) (
   input logic clk,
   input logic rst_n,
   input logic samp_tick,
   input logic cmp_above,
   input logic ind_gnt,
   input logic ind_req,
   input logic ind_rel,
   input logic hs_on,
   input logic ls_on
);
   localparam int unsigned HS_LEN = HS_UNITS * UNIT_CYC;

   logic [15:0] hs_cnt_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hs_cnt_q <= '0;
      else if (hs_on) hs_cnt_q <= hs_cnt_q + 16'd1;
      else            hs_cnt_q <= '0;
   end

   p_req_from_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(ind_req) |-> $past(samp_tick && cmp_above));

   p_req_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_req && !ind_gnt) |=> ind_req);

   p_hs_after_gnt_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ind_req && ind_gnt) |=> (hs_on && !ind_req));

   p_no_overlap_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(hs_on && ls_on));

   p_hs_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_on) |-> (hs_cnt_q == 16'(HS_LEN)));

   p_dead_cycle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(hs_on) |-> (!ls_on ##1 ls_on));

   p_rel_after_ls_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ls_on) |-> ind_rel);

   p_rel_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      ind_rel |=> (!ind_rel && !ind_req));

   p_busy_no_req_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (hs_on || ls_on || ind_rel) |-> !ind_req);
endmodule

bind pfm_buck_ctrl pfm_buck_ctrl_chk #(
   .HS_UNITS (HS_UNITS),
   .UNIT_CYC (UNIT_CYC)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .samp_tick (samp_tick),
   .cmp_above (cmp_above),
   .ind_gnt   (ind_gnt),
   .ind_req   (ind_req),
   .ind_rel   (ind_rel),
   .hs_on     (hs_on),
   .ls_on     (ls_on)
);

// File: tb/pfm_buck_ctrl_tb.sv
module pfm_buck_ctrl_tb_top;
   localparam int HS_UNITS = 8;
   localparam int UNIT_CYC = 2;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       samp_tick = 1'b0;
   logic       cmp_above = 1'b0;
   logic [3:0] vset_code = 4'd0;
   logic       ind_gnt = 1'b0;
   logic       ind_req, ind_rel, hs_on, ls_on;

   int n_chk = 0;
   int n_fail = 0;
   bit done_flag = 1'b0;

   always #2 clk = ~clk;

   pfm_buck_ctrl #(.HS_UNITS(HS_UNITS), .UNIT_CYC(UNIT_CYC)) dut_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .samp_tick (samp_tick),
      .cmp_above (cmp_above),
      .vset_code (vset_code),
      .ind_gnt   (ind_gnt),
      .ind_req   (ind_req),
      .ind_rel   (ind_rel),
      .hs_on     (hs_on),
      .ls_on     (ls_on)
   );

   function automatic int exp_ls_units(input int k);
      real v, r;
      v = 2.2 + 2.8 * k / 15.0;
      r = HS_UNITS * (v - 1.8) / 1.8;
      return $rtoi(r + 0.5);
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic idle_outputs(input string req);
      chk(!ind_req && !ind_rel && !hs_on && !ls_on, req,
          {ind_req, ind_rel, hs_on, ls_on}, 0);
   endtask

   // One full transfer; sampled and driven at falling edges.
   task automatic xfer(input int code, input int gdly, input bit busy_tick,
                       input bit chg_code);
      int n;
      int exp_ls;
      exp_ls = exp_ls_units(code) * UNIT_CYC;
      vset_code = 4'(code);
      samp_tick = 1'b1; cmp_above = 1'b1;
      @(negedge clk);
      samp_tick = 1'b0; cmp_above = 1'($urandom_range(0, 1));
      chk(ind_req && !hs_on, "R2 request after strobe", ind_req, 1);
      for (int i = 0; i < gdly; i++) begin
         @(negedge clk);
         chk(ind_req && !hs_on, "R3 request held", ind_req, 1);
      end
      ind_gnt = 1'b1;
      @(negedge clk);
      ind_gnt = 1'b0;
      chk(hs_on && !ind_req, "R3 high side after grant", hs_on, 1);
      n = 0;
      while (hs_on && n < 500) begin
         chk(!ls_on, "R4 no overlap", ls_on, 0);
         n++;
         samp_tick = busy_tick && (n == 2);
         cmp_above = busy_tick && (n == 2);
         if (chg_code && n == 3) vset_code = 4'(~code);
         @(negedge clk);
      end
      samp_tick = 1'b0; cmp_above = 1'b0;
      chk(n == HS_UNITS * UNIT_CYC, "R5 high-side length", n, HS_UNITS * UNIT_CYC);
      chk(!ls_on && !hs_on && !ind_rel, "R6 dead cycle", ls_on, 0);
      @(negedge clk);
      n = 0;
      while (ls_on && n < 500) begin
         chk(!hs_on, "R4 no overlap", hs_on, 0);
         n++;
         if (busy_tick && n == 1) begin samp_tick = 1'b1; cmp_above = 1'b1; end
         else begin samp_tick = 1'b0; cmp_above = 1'b0; end
         @(negedge clk);
      end
      samp_tick = 1'b0; cmp_above = 1'b0;
      if (chg_code) chk(n == exp_ls, "R8 code captured at grant", n, exp_ls);
      else          chk(n == exp_ls, "R7 low-side length", n, exp_ls);
      chk(ind_rel && !hs_on && !ls_on, "R9 release after low side", ind_rel, 1);
      @(negedge clk);
      idle_outputs("R9 single release then idle");
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         chk(!ind_req, "R10 mid-transfer strobe ignored", ind_req, 0);
      end
   endtask

   initial begin
      void'($urandom(32'd20250));
      #1;
      idle_outputs("R1 outputs during reset");
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      idle_outputs("R1 outputs after reset");

      // Strobe with comparator low: nothing.
      samp_tick = 1'b1; cmp_above = 1'b0;
      @(negedge clk);
      samp_tick = 1'b0;
      chk(!ind_req, "R2 strobe with comparator low", ind_req, 0);
      // Comparator high without strobe: nothing.
      cmp_above = 1'b1;
      repeat (4) begin
         @(negedge clk);
         chk(!ind_req, "R2 comparator without strobe", ind_req, 0);
      end
      cmp_above = 1'b0;

      xfer(0, 0, 1'b0, 1'b0);
      xfer(15, 0, 1'b0, 1'b0);
      xfer(7, 6, 1'b1, 1'b0);
      xfer(2, 1, 1'b0, 1'b1);
      for (int k = 0; k < 16; k++) xfer(k, 0, 1'b0, 1'b0);
      for (int t = 0; t < 40; t++) begin
         xfer(int'($urandom_range(0, 15)), int'($urandom_range(0, 5)),
              1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end

      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done_flag) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end
endmodule